// File: doc/BRIEF.md
# Branch clock gating control unit

This block holds one control register per branch clock. Every branch clock is cut from a shared base clock. Software uses a small memory-mapped bus to turn each branch on or off. The register for a branch carries a run enable and an auto-gating enable. A subset of branches also has a divide-by-two option. The divider is requested through a write-only bit, and the divider setting that is actually in effect is read back through a separate status bit. The block drives one enable per branch, one clock-enable strobe per branch, and a sticky flag per branch that marks a disable sequence done in the wrong order.

Branches are grouped by base clock, and each group has an input that says whether its base clock is running. A branch of the bus class feeds the peripheral branches above it in the same group, so when a bus branch stops, its children stop with it. Turning a branch off takes two writes in order. The first write sets the auto bit while run is still set. A later write clears run. If a write tries to clear run before auto has been set, the branch keeps running and the protocol flag is raised. Accesses to a branch whose base clock is stopped, and accesses to addresses that decode to no branch, get an error response instead of an acknowledge.

Top module: `brgate_ctrl`

## Requirements
- R1: After reset, the branches in the essential mask (default: branches 0 to 3) have run = 1 and their enable high. Every other branch has run = 0. On all branches auto = 0, the divider is inactive and the protocol flag is low.
- R2: Register word layout: bit 0 is run and bit 1 is auto. All other bits read 0, including the write-only bit 5. Writes to bits other than 0, 1 and 5 have no effect.
- R3: On a branch with the divider option (default: branches 2 and 6), writing bit 5 = 1 makes bit 27 read 1 once two clock cycles have passed. On branches without the option, bit 5 is ignored, bit 27 reads 0 and the strobe equals the branch enable.
- R4: When the divider is active, the strobe of the branch is high on every second cycle (8 of 16). When it is inactive, the strobe is high on every cycle the branch is enabled. The mode only switches on a divided-clock boundary.
- R5: A write with run = 0 to a running branch clears run only if auto was already set before that write. If auto was not set, run stays 1 and the flag of that branch goes high. The next write to that branch that does not break the rule clears the flag.
- R6: A child branch's enable is its own gate ANDed with the enable of its parent bus branch. The parent is the nearest lower-numbered bus branch in the same base group (default: branch 4 is the parent of branches 5 to 7).
- R7: With run and auto both set, the branch enable is low while the branch's idle input is high. It is high again one cycle after idle clears. With auto clear, idle has no effect.
- R8: An access to a branch whose base group has base_en low returns an error response with rdata 0. A write made this way changes nothing.
- R9: An access whose byte address is misaligned (addr[1:0] not equal to 0), or whose index addr/4 is not below the branch count, returns an error with rdata 0.
- R10: For every request, exactly one of ack or err is high in the following cycle. Neither one is high without a request in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock; all registers use it |
| rst_n | input | 1 | Active-low synchronous reset |
| base_en | input | N_BASE | Base clock running, one bit per base group |
| idle | input | N_BRANCH | Per-branch idle indication used for auto gating |
| req | input | 1 | Bus access request, one cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Byte address, 4-byte stride per branch |
| wdata | input | 32 | Write data |
| ack | output | 1 | Access completed normally |
| err | output | 1 | Access refused |
| rdata | output | 32 | Read data, valid with ack |
| branch_en | output | N_BRANCH | Effective branch enable |
| div_stb | output | N_BRANCH | Per-branch clock-enable strobe |
| proto_err | output | N_BRANCH | Sticky flag for an out-of-order disable |

## Verification
The register function is driven with reads of reset values and with all-ones writes to a branch without the divider, which shows that reserved and write-only bits are dropped. Divider requests are followed by reads spaced so the two-cycle status delay can be told apart. Disable sequences are tried in both the illegal order and the legal order, which separates a kept run bit from a cleared one. Idle pulses on the bus branch and on a child without auto show gating that reaches the children apart from idle that is ignored. Out-of-range, misaligned and stopped-base accesses are followed by readbacks to show that no write was applied.

// File: rtl/brgate_pkg.sv
`timescale 1ns/1ps
package brgate_pkg;
   localparam int REG_W       = 32;
   localparam int RUN_POS     = 0;
   localparam int AUTO_POS    = 1;
   localparam int DIVREQ_POS  = 5;
   localparam int DIVSTAT_POS = 27;
   localparam int MAX_BR      = 64;
   localparam int MAP_FW      = 4;
   localparam int MAX_BASE    = 16;
   localparam logic [REG_W-1:0] LIVE_MASK = 32'h0800_0003;

   // nearest lower bus branch in the same base group, -1 when none
   function automatic int parent_of(input logic [MAX_BR-1:0] bus_mask,
                                    input logic [MAX_BR*MAP_FW-1:0] base_map,
                                    input int idx);
      int p;
      p = -1;
      for (int j = 0; j < idx; j++) begin
         if (bus_mask[j] && (base_map[j*MAP_FW +: MAP_FW] == base_map[idx*MAP_FW +: MAP_FW]))
            p = j;
      end
      return p;
   endfunction
endpackage

// File: rtl/brgate_decode.sv
`timescale 1ns/1ps
module brgate_decode #(
   parameter int N_BRANCH = 8,
   parameter int N_BASE   = 2,
   parameter int ADDR_W   = 8,
   parameter logic [brgate_pkg::MAX_BR*brgate_pkg::MAP_FW-1:0] BASE_X = '0
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  req,
   input  logic                                  we,
   input  logic [ADDR_W-1:0]                     addr,
   input  logic [N_BASE-1:0]                     base_en,
   input  logic [N_BRANCH-1:0][brgate_pkg::REG_W-1:0] words,
   output logic [N_BRANCH-1:0]                   wr_sel,
   output logic                                  ack,
   output logic                                  err,
   output logic [brgate_pkg::REG_W-1:0]          rdata
);
   import brgate_pkg::*;
   localparam int IDX_W = ADDR_W - 2;

   logic [IDX_W-1:0]  idx;
   logic              aligned, in_range, base_ok, ok;
   logic [MAP_FW-1:0] grp;
   logic [REG_W-1:0]  sel_word;
   logic              ack_q, err_q;
   logic [REG_W-1:0]  rdata_q;

   always_comb begin
      idx      = addr[ADDR_W-1:2];
      aligned  = (addr[1:0] == 2'b00);
      in_range = 1'b0;
      grp      = '0;
      sel_word = '0;
      for (int i = 0; i < N_BRANCH; i++) begin
         if (idx == IDX_W'(i)) begin
            in_range = 1'b1;
            grp      = BASE_X[i*MAP_FW +: MAP_FW];
            sel_word = words[i];
         end
      end
      base_ok = 1'b0;
      for (int b = 0; b < N_BASE; b++) begin
         if (grp == MAP_FW'(b)) base_ok = base_en[b];
      end
      ok = aligned & in_range & base_ok;
      for (int i = 0; i < N_BRANCH; i++) begin
         wr_sel[i] = req & we & ok & (idx == IDX_W'(i));
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack_q   <= 1'b0;
         err_q   <= 1'b0;
         rdata_q <= '0;
      end else begin
         ack_q   <= req & ok;
         err_q   <= req & ~ok;
         rdata_q <= (req & ok & ~we) ? sel_word : '0;
      end
   end

   assign ack   = ack_q;
   assign err   = err_q;
   assign rdata = rdata_q;
endmodule

// File: rtl/brgate_branch.sv
`timescale 1ns/1ps
module brgate_branch #(
   parameter bit HAS_DIV = 1'b0,
   parameter bit RST_RUN = 1'b0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic                         wr_run,
   input  logic                         wr_auto,
   input  logic                         wr_div,
   input  logic                         idle,
   input  logic                         ph,
   output logic                         gate,
   output logic                         perr,
   output logic                         div_mode,
   output logic [brgate_pkg::REG_W-1:0] rd_word
);
   import brgate_pkg::*;

   logic run_q, auto_q, gate_q, perr_q;
   logic bad_clear;
   logic div_stat;

   // clearing run is legal only once auto was set by an earlier write
   assign bad_clear = wr_en & run_q & ~wr_run & ~auto_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q  <= RST_RUN;
         auto_q <= 1'b0;
         perr_q <= 1'b0;
         gate_q <= RST_RUN;
      end else begin
         if (wr_en) begin
            auto_q <= wr_auto;
            run_q  <= wr_run | bad_clear;
            perr_q <= bad_clear;
         end
         gate_q <= run_q & ~(auto_q & idle);
      end
   end

   generate
      if (HAS_DIV) begin : g_div
         logic req_q, sync1_q, sync2_q, mode_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               req_q   <= 1'b0;
               sync1_q <= 1'b0;
               sync2_q <= 1'b0;
               mode_q  <= 1'b0;
            end else begin
               if (wr_en) req_q <= wr_div;
               sync1_q <= req_q;
               sync2_q <= sync1_q;
               // switch only after a divided pulse so no short pulse appears
               if (ph) mode_q <= sync2_q;
            end
         end
         assign div_stat = sync2_q;
         assign div_mode = mode_q;
      end else begin : g_nodiv
         wire unused_div = wr_div ^ ph;
         assign div_stat = 1'b0;
         assign div_mode = 1'b0;
      end
   endgenerate

   always_comb begin
      rd_word              = '0;
      rd_word[RUN_POS]     = run_q;
      rd_word[AUTO_POS]    = auto_q;
      rd_word[DIVSTAT_POS] = div_stat;
   end

   assign gate = gate_q;
   assign perr = perr_q;
endmodule

// File: rtl/brgate_tree.sv
`timescale 1ns/1ps
module brgate_tree #(
   parameter int N_BRANCH = 8,
   parameter logic [brgate_pkg::MAX_BR-1:0] BUS_X = '0,
   parameter logic [brgate_pkg::MAX_BR*brgate_pkg::MAP_FW-1:0] BASE_X = '0
) (
   input  logic [N_BRANCH-1:0] gate,
   output logic [N_BRANCH-1:0] en
);
   generate
      if (BUS_X == '0) begin : g_flat
         assign en = gate;
      end else begin : g_hier
         always_comb begin
            en = gate;
            for (int i = 0; i < N_BRANCH; i++) begin
               if (brgate_pkg::parent_of(BUS_X, BASE_X, i) >= 0)
                  en[i] = gate[i] & en[brgate_pkg::parent_of(BUS_X, BASE_X, i)];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/brgate_ctrl.sv
`timescale 1ns/1ps
module brgate_ctrl #(
   parameter int N_BRANCH = 8,
   parameter int N_BASE   = 2,
   parameter int ADDR_W   = 8,
   parameter logic [N_BRANCH-1:0]   DIV_MASK = 8'h44,
   parameter logic [N_BRANCH-1:0]   BUS_MASK = 8'h10,
   parameter logic [N_BRANCH-1:0]   RST_RUN  = 8'h0F,
   parameter logic [4*N_BRANCH-1:0] BASE_MAP = 32'h1111_0000
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N_BASE-1:0]    base_en,
   input  logic [N_BRANCH-1:0]  idle,
   input  logic                 req,
   input  logic                 we,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [31:0]          wdata,
   output logic                 ack,
   output logic                 err,
   output logic [31:0]          rdata,
   output logic [N_BRANCH-1:0]  branch_en,
   output logic [N_BRANCH-1:0]  div_stb,
   output logic [N_BRANCH-1:0]  proto_err
);
   import brgate_pkg::*;

   localparam logic [MAX_BR-1:0]        BUS_X  = MAX_BR'(BUS_MASK);
   localparam logic [MAX_BR*MAP_FW-1:0] BASE_X = (MAX_BR*MAP_FW)'(BASE_MAP);

   // elaboration-time parameter checks
   if (N_BRANCH < 1 || N_BRANCH > MAX_BR) begin : g_bad_n
      $error("brgate_ctrl: N_BRANCH out of range");
   end
   if (N_BASE < 1 || N_BASE > MAX_BASE) begin : g_bad_base
      $error("brgate_ctrl: N_BASE out of range");
   end
   if (ADDR_W < 3 || ADDR_W > 31 || (64'(1) << (ADDR_W - 2)) < 64'(N_BRANCH)) begin : g_bad_aw
      $error("brgate_ctrl: ADDR_W too small for the branch count");
   end
   for (genvar g = 0; g < N_BRANCH; g++) begin : g_map_chk
      if (int'(BASE_MAP[g*MAP_FW +: MAP_FW]) >= N_BASE) begin : g_bad_map
         $error("brgate_ctrl: BASE_MAP names a missing base group");
      end
   end

   logic [N_BRANCH-1:0]            wr_sel;
   logic [N_BRANCH-1:0][REG_W-1:0] words;
   logic [N_BRANCH-1:0]            gate, mode;
   logic                           ph_q;

   wire unused_wd = ^{wdata[31:6], wdata[4:2]};

   always_ff @(posedge clk) begin
      if (!rst_n) ph_q <= 1'b0;
      else        ph_q <= ~ph_q;
   end

   brgate_decode #(
      .N_BRANCH (N_BRANCH),
      .N_BASE   (N_BASE),
      .ADDR_W   (ADDR_W),
      .BASE_X   (BASE_X)
   ) u_dec (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (req),
      .we      (we),
      .addr    (addr),
      .base_en (base_en),
      .words   (words),
      .wr_sel  (wr_sel),
      .ack     (ack),
      .err     (err),
      .rdata   (rdata)
   );

   for (genvar i = 0; i < N_BRANCH; i++) begin : g_br
      brgate_branch #(
         .HAS_DIV (DIV_MASK[i]),
         .RST_RUN (RST_RUN[i])
      ) u_br (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (wr_sel[i]),
         .wr_run   (wdata[RUN_POS]),
         .wr_auto  (wdata[AUTO_POS]),
         .wr_div   (wdata[DIVREQ_POS]),
         .idle     (idle[i]),
         .ph       (ph_q),
         .gate     (gate[i]),
         .perr     (proto_err[i]),
         .div_mode (mode[i]),
         .rd_word  (words[i])
      );
      assign div_stb[i] = branch_en[i] & (mode[i] ? ph_q : 1'b1);
   end

   brgate_tree #(
      .N_BRANCH (N_BRANCH),
      .BUS_X    (BUS_X),
      .BASE_X   (BASE_X)
   ) u_tree (
      .gate (gate),
      .en   (branch_en)
   );
endmodule

// File: rtl/brgate_chk.sv
`timescale 1ns/1ps
module brgate_chk #(
   parameter int N_BRANCH = 8,
   parameter logic [N_BRANCH-1:0]   DIV_MASK = 8'h44,
   parameter logic [N_BRANCH-1:0]   BUS_MASK = 8'h10,
   parameter logic [4*N_BRANCH-1:0] BASE_MAP = 32'h1111_0000
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req,
   input logic                ack,
   input logic                err,
   input logic [31:0]         rdata,
   input logic [N_BRANCH-1:0] branch_en,
   input logic [N_BRANCH-1:0] div_stb,
   input logic [N_BRANCH-1:0] proto_err
);
   import brgate_pkg::*;
   localparam logic [MAX_BR-1:0]        BUS_X  = MAX_BR'(BUS_MASK);
   localparam logic [MAX_BR*MAP_FW-1:0] BASE_X = (MAX_BR*MAP_FW)'(BASE_MAP);

   assert_one_resp_R10: assert property (@(posedge clk) disable iff (!rst_n)
      req |=> (ack ^ err));
   assert_no_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ack || err) |-> $past(req));
   assert_err_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (rdata == '0));
   assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> ((rdata & ~LIVE_MASK) == '0));

   for (genvar i = 0; i < N_BRANCH; i++) begin : g_b
      assert_stb_R4: assert property (@(posedge clk) disable iff (!rst_n)
         div_stb[i] |-> branch_en[i]);
      assert_perr_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(proto_err[i]) |-> ack);
      if (!DIV_MASK[i]) begin : g_nd
         assert_nodiv_R3: assert property (@(posedge clk) disable iff (!rst_n)
            div_stb[i] == branch_en[i]);
      end
      if (parent_of(BUS_X, BASE_X, i) >= 0) begin : g_p
         assert_parent_R6: assert property (@(posedge clk) disable iff (!rst_n)
            branch_en[i] |-> branch_en[parent_of(BUS_X, BASE_X, i)]);
      end
   end
endmodule

bind brgate_ctrl brgate_chk #(
   .N_BRANCH (N_BRANCH),
   .DIV_MASK (DIV_MASK),
   .BUS_MASK (BUS_MASK),
   .BASE_MAP (BASE_MAP)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req       (req),
   .ack       (ack),
   .err       (err),
   .rdata     (rdata),
   .branch_en (branch_en),
   .div_stb   (div_stb),
   .proto_err (proto_err)
);

// File: tb/brgate_ctrl_test.sv
`timescale 1ns/1ps
module brgate_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  base_en = 2'b11;
   logic [7:0]  idle = '0;
   logic        req = 1'b0, we = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic        ack, err;
   logic [31:0] rdata;
   logic [7:0]  branch_en, div_stb, proto_err;

   int n_run = 0, n_fail = 0;
   logic        s_err;
   logic [31:0] s_rd;

   always #2.5 clk = ~clk;

   brgate_ctrl uut (
      .clk(clk), .rst_n(rst_n), .base_en(base_en), .idle(idle),
      .req(req), .we(we), .addr(addr), .wdata(wdata),
      .ack(ack), .err(err), .rdata(rdata),
      .branch_en(branch_en), .div_stb(div_stb), .proto_err(proto_err)
   );

   typedef struct packed {
      logic        we;
      logic [7:0]  addr;
      logic [31:0] wd;
      logic        xerr;
      logic [31:0] xrd;
   } vec_t;

   localparam int NV = 21;
   localparam vec_t VT [NV] = '{
      '{1'b0, 8'h00, 32'h0,         1'b0, 32'h0000_0001}, // R1 essential
      '{1'b0, 8'h0C, 32'h0,         1'b0, 32'h0000_0001}, // R1 essential
      '{1'b0, 8'h10, 32'h0,         1'b0, 32'h0000_0000}, // R1 non-essential
      '{1'b0, 8'h1C, 32'h0,         1'b0, 32'h0000_0000}, // R1 non-essential
      '{1'b1, 8'h10, 32'hFFFF_FFFF, 1'b0, 32'h0000_0000}, // R2 all ones
      '{1'b0, 8'h10, 32'h0,         1'b0, 32'h0000_0003}, // R2 R3 readback
      '{1'b1, 8'h14, 32'h0000_0001, 1'b0, 32'h0000_0000},
      '{1'b0, 8'h14, 32'h0,         1'b0, 32'h0000_0001},
      '{1'b1, 8'h20, 32'h0000_FFFF, 1'b1, 32'h0000_0000}, // R9 out of range
      '{1'b0, 8'h22, 32'h0,         1'b1, 32'h0000_0000}, // R9 misaligned
      '{1'b1, 8'h18, 32'h0000_0021, 1'b0, 32'h0000_0000}, // R3 div request
      '{1'b0, 8'h14, 32'h0,         1'b0, 32'h0000_0001},
      '{1'b0, 8'h14, 32'h0,         1'b0, 32'h0000_0001},
      '{1'b0, 8'h18, 32'h0,         1'b0, 32'h0800_0001}, // R3 status
      '{1'b1, 8'h0C, 32'h0,         1'b0, 32'h0000_0000}, // R5 illegal clear
      '{1'b0, 8'h0C, 32'h0,         1'b0, 32'h0000_0001}, // R5 run kept
      '{1'b1, 8'h0C, 32'h0000_0003, 1'b0, 32'h0000_0000}, // R5 set auto
      '{1'b1, 8'h0C, 32'h0000_0002, 1'b0, 32'h0000_0000}, // R5 legal clear
      '{1'b0, 8'h0C, 32'h0,         1'b0, 32'h0000_0002}, // R5 run cleared
      '{1'b1, 8'h04, 32'h0800_0003, 1'b0, 32'h0000_0000}, // R2 bit27 write
      '{1'b0, 8'h04, 32'h0,         1'b0, 32'h0000_0003}  // R2 readback
   };

   task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // caller is at a negedge; result is sampled one negedge later
   task automatic txn(input logic w, input logic [7:0] a, input logic [31:0] d);
      req = 1'b1; we = w; addr = a; wdata = d;
      @(negedge clk);
      s_err = err;
      s_rd  = rdata;
      check(ack == ~err, "R10 one response", {30'b0, ack, err}, 32'h0);
      req = 1'b0; we = 1'b0; wdata = '0;
   endtask

   task automatic count_stb(input int b, output int cnt);
      cnt = 0;
      for (int k = 0; k < 16; k++) begin
         @(negedge clk);
         if (div_stb[b]) cnt++;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog R10 actual=%0d expected=%0d", 20000, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      int c;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(branch_en == 8'h0F, "R1 reset enables", {24'b0, branch_en}, 32'h0F);
      check(proto_err == 8'h00, "R1 reset flags", {24'b0, proto_err}, 32'h0);
      check(div_stb == 8'h0F, "R1 reset strobes", {24'b0, div_stb}, 32'h0F);
      check(!ack && !err, "R10 idle bus", {30'b0, ack, err}, 32'h0);

      for (int v = 0; v < NV; v++) begin
         txn(VT[v].we, VT[v].addr, VT[v].wd);
         check(s_err == VT[v].xerr, $sformatf("R10 vec %0d err", v), {31'b0, s_err}, {31'b0, VT[v].xerr});
         check(s_rd == VT[v].xrd, $sformatf("R2 vec %0d rdata", v), s_rd, VT[v].xrd);
      end

      // R4: branch 6 divided, branch 5 not
      count_stb(6, c);
      check(c == 8, "R4 divided strobe count", c, 8);
      count_stb(5, c);
      check(c == 16, "R4 undivided strobe count", c, 16);
      txn(1'b1, 8'h18, 32'h0000_0001);
      repeat (8) @(negedge clk);
      count_stb(6, c);
      check(c == 16, "R4 divider released", c, 16);

      // R6 / R7: idle on bus branch 4 (run and auto set) stops its children
      idle[4] = 1'b1;
      @(negedge clk);
      check(branch_en[4] == 1'b0, "R7 bus gated by idle", branch_en[4], 0);
      check(branch_en[5] == 1'b0, "R6 child follows bus", branch_en[5], 0);
      check(branch_en[6] == 1'b0, "R6 child follows bus", branch_en[6], 0);
      idle[4] = 1'b0;
      @(negedge clk);
      check(branch_en[4] == 1'b1, "R7 bus back after idle", branch_en[4], 1);
      check(branch_en[5] == 1'b1, "R6 child back", branch_en[5], 1);
      idle[5] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check(branch_en[5] == 1'b1, "R7 idle ignored without auto", branch_en[5], 1);
      idle[5] = 1'b0;

      // R5: illegal clear on branch 0
      txn(1'b1, 8'h00, 32'h0);
      check(proto_err[0] == 1'b1, "R5 flag raised", proto_err[0], 1);
      @(negedge clk);
      check(branch_en[0] == 1'b1, "R5 branch kept running", branch_en[0], 1);
      txn(1'b1, 8'h00, 32'h0000_0001);
      check(proto_err[0] == 1'b0, "R5 flag cleared", proto_err[0], 0);

      // R8: base group 1 stopped
      base_en = 2'b01;
      txn(1'b0, 8'h14, 32'h0);
      check(s_err == 1'b1, "R8 read refused", s_err, 1);
      check(s_rd == 32'h0, "R8 read data zero", s_rd, 0);
      txn(1'b1, 8'h14, 32'h0000_0003);
      check(s_err == 1'b1, "R8 write refused", s_err, 1);
      base_en = 2'b11;
      txn(1'b0, 8'h14, 32'h0);
      check(s_rd == 32'h0000_0001, "R8 write not applied", s_rd, 1);

      @(negedge clk);
      check(!ack && !err, "R10 no response without request", {30'b0, ack, err}, 32'h0);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule